// File: doc/BRIEF.md
# Character String Equality Comparator

This block decides whether two character strings are identical bit for bit. Characters are six bits wide and arrive one per clock, starting with the least significant location and working upward. A compare is launched with a start pulse that carries the operand length and the mode. It then consumes exactly that many characters and leaves a two-state condition, equal or unequal, that holds until the next compare finishes.

In field mode both operands are streamed in, on `char_a` and `char_b`. In constant mode the first operand is a two-character constant captured at start. The right constant character meets the lowest location and the left one meets the next location up. Any further location of the streamed operand is compared against the all-zero space code. No bit receives any sign treatment, and a space never matches a zero digit.

A mismatch settles the outcome at once and raises `ne_found`. The block still accepts the remaining characters, so the stream stays aligned, and then pulses `done`.

Top module: `charseq_eq_cmp`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `cond_eq` and `ne_found` are all 0.
- R2: In field mode (`const_mode`=0), `cond_eq` becomes 1 only if every pair of six-bit characters matches in all bits, the two zone bits (bit 5, bit 4) included. A difference in any single bit at any location gives 0.
- R3: The space code 6'b000000 and the zero digit 6'b000011 compare unequal, in both modes.
- R4: `ne_found` goes to 1 on the clock edge that consumes the first differing pair. It stays at 1 while the rest of the characters are consumed, and it is cleared only when a new compare is accepted.
- R5: An accepted `start` (one with `busy`=0) sets `busy` on the next edge. The compare ends after exactly the effective length of characters has been consumed, counting only cycles with `char_valid`=1. A `len_in` of 0 counts as 1, and a value above MAX_LEN (default 961) counts as MAX_LEN.
- R6: In constant mode (`const_mode`=1), location 0 is compared with the `k_right` captured at start and location 1 with the captured `k_left`. `char_a` has no effect.
- R7: In constant mode, every location from index 2 upward is compared against 6'b000000.
- R8: `cond_eq` changes only on the edge that ends a compare. A `start` raised while `busy`=1 is ignored, including in the cycle that consumes the final character.
- R9: `done` is a one-cycle pulse on the edge that consumes the final character. On that same edge `busy` falls and `cond_eq` takes the new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a compare (accepted only while idle) |
| const_mode | input | 1 | 0: field mode, 1: constant mode |
| len_in | input | LEN_W | Operand length in characters |
| k_left | input | 6 | Left constant character (location 1) |
| k_right | input | 6 | Right constant character (location 0) |
| char_valid | input | 1 | A character pair is present this cycle |
| char_a | input | 6 | First-operand character (field mode) |
| char_b | input | 6 | Second-operand character |
| busy | output | 1 | Compare in progress |
| done | output | 1 | One-cycle end-of-compare pulse |
| cond_eq | output | 1 | Held condition: 1 equal, 0 unequal |
| ne_found | output | 1 | A mismatch has been seen in the current or last compare |

## Verification
The colliding case is a new `start` that arrives in the very cycle the final character is consumed, which is also the cycle in which the result is written. The bench raises `start` with a different length and mode on that last character, and also on a middle character. It then requires that `busy` is low right after `done` and that the held condition survives the idle cycles that follow. A second overlap is a mismatch on the final character, where `ne_found` and `cond_eq` must both settle on the same edge. A behavioural model judges each of these cycle by cycle.

// File: rtl/chareq_pkg.sv
package chareq_pkg;

    localparam int unsigned CHAR_BITS = 6;

    typedef logic [CHAR_BITS-1:0] char_t;

    // padding character for constant-mode positions beyond the constant
    localparam char_t SPACE_CODE = '0;

    typedef enum logic {
        CMP_FIELD = 1'b0,
        CMP_CONST = 1'b1
    } cmp_mode_e;

    typedef enum logic {
        COND_NE = 1'b0,
        COND_EQ = 1'b1
    } cond_e;

    typedef enum logic [1:0] {
        POS_FIRST  = 2'd0,
        POS_SECOND = 2'd1,
        POS_BEYOND = 2'd2
    } pos_e;

    typedef struct packed {
        cmp_mode_e mode;
        char_t     k_hi;   // left constant character
        char_t     k_lo;   // right constant character
    } cmp_cfg_t;

    function automatic logic char_differs(input char_t a, input char_t b);
        return |(a ^ b);
    endfunction

endpackage

// File: rtl/chareq_seq.sv
module chareq_seq
    import chareq_pkg::*;
#(
    parameter int unsigned LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             step,
    output logic             last,
    output pos_e             pos
);
    logic [LEN_W-1:0] remain_q;
    pos_e             pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            pos_q    <= POS_FIRST;
        end else if (load) begin
            remain_q <= load_len;
            pos_q    <= POS_FIRST;
        end else if (step) begin
            remain_q <= remain_q - LEN_W'(1);
            case (pos_q)
                POS_FIRST:  pos_q <= POS_SECOND;
                default:    pos_q <= POS_BEYOND;
            endcase
        end
    end

    assign last = (remain_q == LEN_W'(1));
    assign pos  = pos_q;
endmodule

// File: rtl/chareq_opsel.sv
module chareq_opsel
    import chareq_pkg::*;
(
    input  cmp_cfg_t cfg,
    input  pos_e     pos,
    input  char_t    field_char,
    output char_t    op_a
);
    always_comb begin
        if (cfg.mode == CMP_FIELD) begin
            op_a = field_char;
        end else begin
            case (pos)
                POS_FIRST:  op_a = cfg.k_lo;
                POS_SECOND: op_a = cfg.k_hi;
                default:    op_a = SPACE_CODE;
            endcase
        end
    end
endmodule

// File: rtl/chareq_acc.sv
module chareq_acc
    import chareq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  step,
    input  logic  finish,
    input  char_t op_a,
    input  char_t op_b,
    output logic  mism,
    output cond_e cond
);
    logic  mism_q;
    cond_e cond_q;
    logic  mism_next;

    assign mism_next = mism_q | char_differs(op_a, op_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            mism_q <= 1'b0;
            cond_q <= COND_NE;
        end else begin
            if (clear)
                mism_q <= 1'b0;
            else if (step)
                mism_q <= mism_next;
            if (finish)
                cond_q <= mism_next ? COND_NE : COND_EQ;
        end
    end

    assign mism = mism_q;
    assign cond = cond_q;
endmodule

// File: rtl/charseq_eq_cmp.sv
module charseq_eq_cmp
    import chareq_pkg::*;
#(
    parameter int unsigned MAX_LEN = 961,
    parameter int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             const_mode,
    input  logic [LEN_W-1:0] len_in,
    input  logic [5:0]       k_left,
    input  logic [5:0]       k_right,
    input  logic             char_valid,
    input  logic [5:0]       char_a,
    input  logic [5:0]       char_b,
    output logic             busy,
    output logic             done,
    output logic             cond_eq,
    output logic             ne_found
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    logic             busy_q, done_q;
    cmp_cfg_t         cfg_q;
    logic             accept, step, finish, last;
    logic [LEN_W-1:0] eff_len;
    pos_e             pos;
    char_t            op_a;
    cond_e            cond;

    assign accept = start & ~busy_q;
    assign step   = busy_q & char_valid;
    assign finish = step & last;

    always_comb begin
        if (len_in == '0)
            eff_len = LEN_ONE;
        else if (len_in > LEN_MAX)
            eff_len = LEN_MAX;
        else
            eff_len = len_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cfg_q  <= '0;
        end else begin
            done_q <= finish;
            if (accept) begin
                busy_q     <= 1'b1;
                cfg_q.mode <= const_mode ? CMP_CONST : CMP_FIELD;
                cfg_q.k_hi <= k_left;
                cfg_q.k_lo <= k_right;
            end else if (finish) begin
                busy_q <= 1'b0;
            end
        end
    end

    chareq_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_len (eff_len),
        .step     (step),
        .last     (last),
        .pos      (pos)
    );

    chareq_opsel u_opsel (
        .cfg        (cfg_q),
        .pos        (pos),
        .field_char (char_a),
        .op_a       (op_a)
    );

    chareq_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .step   (step),
        .finish (finish),
        .op_a   (op_a),
        .op_b   (char_b),
        .mism   (ne_found),
        .cond   (cond)
    );

    assign busy    = busy_q;
    assign done    = done_q;
    assign cond_eq = (cond == COND_EQ);
endmodule

// File: rtl/chareq_chk.sv
module chareq_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic cond_eq,
    input logic ne_found
);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !cond_eq && !ne_found));

    assert_ne_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && ne_found) |=> ne_found);

    assert_ne_matches_result_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> (cond_eq == !ne_found));

    assert_start_accepted_R5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_cond_held_R8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cond_eq));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_fall_done_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);
endmodule

bind charseq_eq_cmp chareq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .cond_eq  (cond_eq),
    .ne_found (ne_found)
);

// File: tb/charseq_eq_cmp_tb.sv
module charseq_eq_cmp_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXL = 961;
    localparam int LW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          const_mode = 1'b0;
    logic [LW-1:0] len_in = '0;
    logic [5:0]    k_left = '0, k_right = '0;
    logic          char_valid = 1'b0;
    logic [5:0]    char_a = '0, char_b = '0;
    logic          busy, done, cond_eq, ne_found;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [5:0] ga[$];
    logic [5:0] gb[$];

    // reference model state
    bit m_busy = 0, m_done = 0, m_cond = 0, m_mis = 0, m_rst = 1, m_mode = 0, armed = 0;
    int m_left = 0, m_pos = 0;
    logic [5:0] m_kl = 0, m_kr = 0, opa;

    always #(CLK_PERIOD/2) clk = ~clk;

    charseq_eq_cmp #(.MAX_LEN(MAXL), .LEN_W(LW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .const_mode(const_mode),
        .len_in(len_in), .k_left(k_left), .k_right(k_right),
        .char_valid(char_valid), .char_a(char_a), .char_b(char_b),
        .busy(busy), .done(done), .cond_eq(cond_eq), .ne_found(ne_found)
    );

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cond = 0; m_mis = 0; m_left = 0; m_pos = 0; m_rst = 1;
        end else begin
            m_rst = 0;
            m_done = 0;
            if (m_busy) begin
                if (char_valid) begin
                    if (m_mode) opa = (m_pos == 0) ? m_kr : (m_pos == 1) ? m_kl : 6'h00;
                    else        opa = char_a;
                    if (opa !== char_b) m_mis = 1;
                    m_pos++;
                    m_left--;
                    if (m_left == 0) begin
                        m_busy = 0; m_done = 1; m_cond = !m_mis;
                    end
                end
            end else if (start) begin
                m_busy = 1; m_mode = const_mode; m_kl = k_left; m_kr = k_right;
                m_pos = 0; m_mis = 0;
                m_left = (len_in == 0) ? 1 : (int'(len_in) > MAXL) ? MAXL : int'(len_in);
            end
        end
        armed = 1;
    end

    always @(negedge clk) begin
        if (armed) begin
            chk(busy,     m_busy, m_rst ? "R1" : "R5");
            chk(done,     m_done, m_rst ? "R1" : "R9");
            chk(cond_eq,  m_cond, m_rst ? "R1" : "R8");
            chk(ne_found, m_mis,  m_rst ? "R1" : "R4");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog R5: got running expected finished at cycle %0d", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic run_cmp(input bit cm, input int lenv, input logic [5:0] kl,
                           input logic [5:0] kr, input int gap, input int ss);
        int n;
        n = ga.size();
        @(negedge clk);
        start = 1; const_mode = cm; len_in = LW'(lenv); k_left = kl; k_right = kr;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < n; i++) begin
            char_valid = 1; char_a = ga[i]; char_b = gb[i];
            if (i == ss) begin start = 1; len_in = LW'(3); const_mode = ~cm; end
            @(negedge clk);
            start = 0; char_valid = 0;
            if (gap != 0 && i % 2 == 0 && i < n - 1) @(negedge clk);
        end
        chk(done, 1'b1, "R9");
        chk(busy, 1'b0, "R9");
    endtask

    task automatic set2(input logic [5:0] a0, a1, b0, b1);
        ga = {a0, a1}; gb = {b0, b1};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy, 1'b0, "R1");
        chk(cond_eq, 1'b0, "R1");
        rst = 0;

        // R2: all bits equal, then X-bit and Y-bit differences
        ga = {6'h05, 6'h2A, 6'h3F, 6'h11}; gb = ga;
        run_cmp(0, 4, 0, 0, 0, -1); chk(cond_eq, 1'b1, "R2");
        gb = {6'h05, 6'h2A, 6'h1F, 6'h11};
        run_cmp(0, 4, 0, 0, 0, -1); chk(cond_eq, 1'b0, "R2");
        gb = {6'h05, 6'h2A, 6'h3F, 6'h01};
        run_cmp(0, 4, 0, 0, 0, -1); chk(cond_eq, 1'b0, "R2");

        // R3: space against zero digit
        ga = {6'h00}; gb = {6'h03};
        run_cmp(0, 1, 0, 0, 0, -1); chk(cond_eq, 1'b0, "R3");
        ga = {6'h3F}; gb = {6'h00};
        run_cmp(1, 1, 6'h00, 6'h03, 0, -1); chk(cond_eq, 1'b0, "R3");

        // R4: first-location mismatch, rest equal
        ga = {6'h01, 6'h02, 6'h03, 6'h04, 6'h05}; gb = {6'h21, 6'h02, 6'h03, 6'h04, 6'h05};
        run_cmp(0, 5, 0, 0, 0, -1);
        chk(ne_found, 1'b1, "R4"); chk(cond_eq, 1'b0, "R4");

        // R5: zero length, gaps, oversize length
        ga = {6'h09}; gb = {6'h09};
        run_cmp(0, 0, 0, 0, 0, -1); chk(cond_eq, 1'b1, "R5");
        ga = {6'h01, 6'h12, 6'h23, 6'h34, 6'h05, 6'h16}; gb = ga;
        run_cmp(0, 6, 0, 0, 1, -1); chk(cond_eq, 1'b1, "R5");
        ga.delete(); gb.delete();
        for (int i = 0; i < MAXL; i++) begin ga.push_back(6'(i)); gb.push_back(6'(i)); end
        run_cmp(0, 1000, 0, 0, 0, -1); chk(cond_eq, 1'b1, "R5");

        // R6: constant placement, char_a ignored
        ga = {6'h3F}; gb = {6'h21};
        run_cmp(1, 1, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b1, "R6");
        gb = {6'h07};
        run_cmp(1, 1, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b0, "R6");
        set2(6'h15, 6'h2A, 6'h21, 6'h07);
        run_cmp(1, 2, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b1, "R6");
        set2(6'h21, 6'h07, 6'h07, 6'h21);
        run_cmp(1, 2, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b0, "R6");

        // R7: space padding beyond the constant
        ga = {6'h3F, 6'h3F, 6'h3F, 6'h3F}; gb = {6'h21, 6'h07, 6'h00, 6'h00};
        run_cmp(1, 4, 6'h07, 6'h21, 1, -1); chk(cond_eq, 1'b1, "R7");
        gb = {6'h21, 6'h07, 6'h00, 6'h01};
        run_cmp(1, 4, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b0, "R7");
        gb = {6'h21, 6'h07, 6'h03, 6'h00};
        run_cmp(1, 4, 6'h07, 6'h21, 0, -1); chk(cond_eq, 1'b0, "R7");

        // R8: start while busy, including on the final character
        ga = {6'h0A, 6'h0B, 6'h0C, 6'h0D}; gb = ga;
        run_cmp(0, 4, 0, 0, 0, 1); chk(cond_eq, 1'b1, "R8");
        ga = {6'h0A, 6'h0B, 6'h0C}; gb = {6'h0A, 6'h0B, 6'h0E};
        run_cmp(0, 3, 0, 0, 0, 2); chk(cond_eq, 1'b0, "R8");
        @(negedge clk); chk(busy, 1'b0, "R8");
        repeat (4) @(negedge clk);
        chk(cond_eq, 1'b0, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule